// File: doc/BRIEF.md
# Zero-Page Read-Modify-Write Bus Sequencer

This block drives the memory-side steps of an 8-bit processor instruction once its opcode has been fetched. A one-cycle start pulse hands it the opcode, the address of the operand byte, the X index and the accumulator. It then issues one bus access per clock on a synchronous byte port whose read data arrives in the cycle after the address is shown. It forms the effective address in page zero, with or without the X offset. It carries out a load, a store or an increment, updates the zero and negative flags, and reports the advanced program counter. It pulses `done` on the final cycle.

The access class of the opcode selects the steps. Read-modify-write (increment) reads the target, writes the unmodified byte back, then writes the incremented byte. Write (store) puts the accumulator on the bus in the cycle after the address byte arrives. Read (load) reads there and returns the byte to the accumulator one cycle later. The indexed forms first spend one idle cycle. The sum of base and X is kept to 8 bits.

The states are IDLE, IXWAIT (indexed idle cycle), FETCH (operand byte at PC), ADDR (access at the effective address), DUMMY (write-back of the old byte), FINAL (write of the new byte) and LDWB (load write-back). The transitions are: IDLE to IXWAIT on an accepted indexed opcode, and IDLE to FETCH on an accepted direct one. IXWAIT goes to FETCH, and FETCH goes to ADDR. From ADDR the sequencer goes to DUMMY for increment, to LDWB for load, and back to IDLE for store. DUMMY goes to FINAL, and FINAL and LDWB both go to IDLE.

Top module: `zp_rmw_seq`

## Requirements
- R1: After reset the block is idle with `mem_we`, `done`, `acc_we` and `illegal` low, `pc_out` = 0, and both flags 0.
- R2: Opcodes 0xE6 (increment), 0xA5 (load) and 0x85 (store) use direct page-zero addressing. The operand byte is read at `pc_in`, and the effective address is that byte with the upper 8 address bits zero.
- R3: Opcodes 0xF6 (increment), 0xB5 (load) and 0x95 (store) are indexed. After start they spend one cycle with no write, then read the operand byte at `pc_in`. Their effective address is (base + X) mod 256.
- R4: An increment reads the target, writes the unmodified byte back in the next cycle, and writes the byte plus one (mod 256) in the cycle after that. `mem_we` is high in exactly those two cycles.
- R5: After an increment, `flag_z` is 1 exactly when the new byte is 0, and `flag_n` equals bit 7 of the new byte.
- R6: A load reads the effective address in the cycle after the operand byte, then raises `acc_we` for one cycle with `acc_wdata` equal to the byte read. Its Z/N follow that byte.
- R7: A store writes `acc_in` to the effective address in the cycle after the operand byte, and leaves both flags unchanged.
- R8: Counted from the cycle after start, the busy cycles are: increment 4 (direct) or 5 (indexed), load 3 or 4, store 2 or 3. `done` is high only in the last of them.
- R9: After any supported instruction, `pc_out` equals `pc_in` + 1.
- R10: Any other opcode raises `illegal` for the one cycle after start. It gives no bus write, no `done` and no `acc_we`, and `pc_out` and the flags stay as they were.
- R11: `start` while an instruction is running is ignored. The running sequence and its results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| opcode | input | 8 | Fetched opcode |
| pc_in | input | 16 | Address of the operand byte |
| x_in | input | 8 | X index register |
| acc_in | input | 8 | Accumulator value for stores |
| mem_rdata | input | 8 | Read data, valid the cycle after the address |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Bus write data |
| mem_we | output | 1 | Bus write enable |
| acc_we | output | 1 | Accumulator write strobe (loads) |
| acc_wdata | output | 8 | Value for the accumulator |
| pc_out | output | 16 | Program counter after the operand fetch |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| done | output | 1 | Last cycle of an instruction |
| illegal | output | 1 | Unsupported opcode seen at start |

## Verification
Start is sampled on one rising edge, and the first sequencer cycle is visible at the following falling edge. From there each bus access, write, `acc_we` and `done` belongs to one exact cycle of the lists in R3 to R8. The bench queues one expected entry per cycle when it raises start, and pops and compares one entry on every falling edge. The flags and `pc_out` are registered, so they are compared on the first idle falling edge after `done`. `illegal` is compared one cycle after start. The memory contents left by stores and increments are checked in the bench's own memory model after completion.

// File: rtl/zp_seq_pkg.sv
package zp_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IXWAIT,
        ST_FETCH,
        ST_ADDR,
        ST_DUMMY,
        ST_FINAL,
        ST_LDWB
    } seq_state_e;

    typedef enum logic [1:0] {
        AC_READ,
        AC_WRITE,
        AC_RMW
    } access_e;

    typedef struct packed {
        logic    legal;
        logic    indexed;
        access_e acc;
    } op_info_t;

endpackage

// File: rtl/zp_decode.sv
module zp_decode
    import zp_seq_pkg::*;
#(
    parameter logic [7:0] OP_INC_D = 8'hE6,
    parameter logic [7:0] OP_INC_X = 8'hF6,
    parameter logic [7:0] OP_LD_D  = 8'hA5,
    parameter logic [7:0] OP_LD_X  = 8'hB5,
    parameter logic [7:0] OP_ST_D  = 8'h85,
    parameter logic [7:0] OP_ST_X  = 8'h95
) (
    input  logic [7:0] opcode,
    output op_info_t   info
);

    always_comb begin
        info = '{legal: 1'b0, indexed: 1'b0, acc: AC_READ};
        case (opcode)
            OP_INC_D: info = '{legal: 1'b1, indexed: 1'b0, acc: AC_RMW};
            OP_INC_X: info = '{legal: 1'b1, indexed: 1'b1, acc: AC_RMW};
            OP_LD_D:  info = '{legal: 1'b1, indexed: 1'b0, acc: AC_READ};
            OP_LD_X:  info = '{legal: 1'b1, indexed: 1'b1, acc: AC_READ};
            OP_ST_D:  info = '{legal: 1'b1, indexed: 1'b0, acc: AC_WRITE};
            OP_ST_X:  info = '{legal: 1'b1, indexed: 1'b1, acc: AC_WRITE};
            default:  info = '{legal: 1'b0, indexed: 1'b0, acc: AC_READ};
        endcase
    end

endmodule

// File: rtl/zp_addr_gen.sv
module zp_addr_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    input  logic              use_index,
    output logic [DATA_W-1:0] ea
);

    logic [DATA_W-1:0] offset;

    always_comb begin
        offset = use_index ? index : '0;
        ea     = base + offset;
    end

endmodule

// File: rtl/zp_seq_fsm.sv
module zp_seq_fsm
    import zp_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  op_info_t   dec,
    output seq_state_e state,
    output logic       cur_indexed,
    output access_e    cur_acc,
    output logic       accept,
    output logic       done,
    output logic       illegal
);

    seq_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cur_indexed <= 1'b0;
            cur_acc     <= AC_READ;
            illegal     <= 1'b0;
        end else begin
            state   <= state_nx;
            illegal <= (state == ST_IDLE) && start && !dec.legal;
            if (accept) begin
                cur_indexed <= dec.indexed;
                cur_acc     <= dec.acc;
            end
        end
    end

    always_comb begin
        accept   = (state == ST_IDLE) && start && dec.legal;
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = dec.indexed ? ST_IXWAIT : ST_FETCH;
            ST_IXWAIT: state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_ADDR;
            ST_ADDR: begin
                if (cur_acc == AC_RMW)        state_nx = ST_DUMMY;
                else if (cur_acc == AC_WRITE) state_nx = ST_IDLE;
                else                          state_nx = ST_LDWB;
            end
            ST_DUMMY:  state_nx = ST_FINAL;
            ST_FINAL:  state_nx = ST_IDLE;
            ST_LDWB:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        done = 1'b0;
        unique case (state)
            ST_ADDR:  done = (cur_acc == AC_WRITE);
            ST_FINAL: done = 1'b1;
            ST_LDWB:  done = 1'b1;
            default:  done = 1'b0;
        endcase
    end

    // R8
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_IDLE));

    // R4
    dummy_to_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUMMY) |=> (state == ST_FINAL));

    // R11
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_ADDR));

endmodule

// File: rtl/zp_rmw_seq.sv
module zp_rmw_seq
    import zp_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              acc_we,
    output logic [DATA_W-1:0] acc_wdata,
    output logic [ADDR_W-1:0] pc_out,
    output logic              flag_z,
    output logic              flag_n,
    output logic              done,
    output logic              illegal
);

    localparam int PAD_W = ADDR_W - DATA_W;

    op_info_t          dec;
    seq_state_e        state;
    logic              cur_indexed;
    access_e           cur_acc;
    logic              accept;
    logic [DATA_W-1:0] ea_now;
    logic [DATA_W-1:0] ea_q;
    logic [DATA_W-1:0] x_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] inc_val;

    zp_decode u_dec (
        .opcode (opcode),
        .info   (dec)
    );

    zp_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dec         (dec),
        .state       (state),
        .cur_indexed (cur_indexed),
        .cur_acc     (cur_acc),
        .accept      (accept),
        .done        (done),
        .illegal     (illegal)
    );

    zp_addr_gen #(.DATA_W(DATA_W)) u_agen (
        .base      (mem_rdata),
        .index     (x_q),
        .use_index (cur_indexed),
        .ea        (ea_now)
    );

    assign inc_val = old_q + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out <= '0;
            x_q    <= '0;
            ea_q   <= '0;
            old_q  <= '0;
            flag_z <= 1'b0;
            flag_n <= 1'b0;
        end else begin
            if (accept) begin
                pc_out <= pc_in;
                x_q    <= x_in;
            end
            unique case (state)
                ST_FETCH: pc_out <= pc_out + 1'b1;
                ST_ADDR:  ea_q   <= ea_now;
                ST_DUMMY: old_q  <= mem_rdata;
                ST_FINAL: begin
                    flag_z <= (inc_val == '0);
                    flag_n <= inc_val[DATA_W-1];
                end
                ST_LDWB: begin
                    flag_z <= (mem_rdata == '0);
                    flag_n <= mem_rdata[DATA_W-1];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        acc_we    = 1'b0;
        acc_wdata = mem_rdata;
        unique case (state)
            ST_FETCH: mem_addr = pc_out;
            ST_ADDR: begin
                mem_addr = {{PAD_W{1'b0}}, ea_now};
                if (cur_acc == AC_WRITE) begin
                    mem_we    = 1'b1;
                    mem_wdata = acc_in;
                end
            end
            ST_DUMMY: begin
                mem_addr  = {{PAD_W{1'b0}}, ea_q};
                mem_we    = 1'b1;
                mem_wdata = mem_rdata;
            end
            ST_FINAL: begin
                mem_addr  = {{PAD_W{1'b0}}, ea_q};
                mem_we    = 1'b1;
                mem_wdata = inc_val;
            end
            ST_LDWB: acc_we = 1'b1;
            default: ;
        endcase
    end

    // R4
    rmw_final_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_wdata == $past(mem_wdata) + 1'b1) && (mem_addr == $past(mem_addr)));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !done && !acc_we));

    // R7
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_FINAL && state != ST_LDWB) |=> ($stable(flag_z) && $stable(flag_n)));

    // R9
    pc_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !accept) |=> $stable(pc_out));

endmodule

// File: tb/zp_rmw_seq_tb.sv
module zp_rmw_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  x_in = 8'h00;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic        acc_we;
    logic [7:0]  acc_wdata;
    logic [15:0] pc_out;
    logic        flag_z;
    logic        flag_n;
    logic        done;
    logic        illegal;

    always #5 clk = ~clk;

    zp_rmw_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .pc_in     (pc_in),
        .x_in      (x_in),
        .acc_in    (acc_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc_we    (acc_we),
        .acc_wdata (acc_wdata),
        .pc_out    (pc_out),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .done      (done),
        .illegal   (illegal)
    );

    logic [7:0] mem [0:65535];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    typedef struct {
        bit         chk_addr;
        logic [15:0] addr;
        bit         we;
        logic [7:0] wd;
        bit         dn;
        bit         awe;
        logic [7:0] ad;
        bit         ill;
        int         req;
    } cyc_t;

    cyc_t        q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          running = 1'b0;
    logic [15:0] exp_pc = 16'h0000;
    bit          exp_z = 1'b0;
    bit          exp_n = 1'b0;

    task automatic fail_line(input int req, input string what, input int act, input int expv);
        $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
    endtask

    always @(negedge clk) begin
        if (rst_n && running) begin
            bit bad;
            bad = 1'b0;
            n_chk++;
            if (q.size() > 0) begin
                cyc_t e;
                e = q.pop_front();
                if (e.chk_addr && mem_addr !== e.addr) begin
                    fail_line(e.req, "mem_addr", mem_addr, e.addr); bad = 1'b1;
                end
                if (mem_we !== e.we) begin
                    fail_line(e.req, "mem_we", mem_we, e.we); bad = 1'b1;
                end
                if (e.we && mem_wdata !== e.wd) begin
                    fail_line(e.req, "mem_wdata", mem_wdata, e.wd); bad = 1'b1;
                end
                if (done !== e.dn) begin
                    // R8: done only in the last busy cycle
                    fail_line(8, "done", done, e.dn); bad = 1'b1;
                end
                if (acc_we !== e.awe) begin
                    // R6
                    fail_line(6, "acc_we", acc_we, e.awe); bad = 1'b1;
                end
                if (e.awe && acc_wdata !== e.ad) begin
                    fail_line(6, "acc_wdata", acc_wdata, e.ad); bad = 1'b1;
                end
                if (illegal !== e.ill) begin
                    // R10
                    fail_line(10, "illegal", illegal, e.ill); bad = 1'b1;
                end
            end else begin
                if (mem_we !== 1'b0) begin fail_line(8, "idle mem_we", mem_we, 0); bad = 1'b1; end
                if (done !== 1'b0) begin fail_line(8, "idle done", done, 0); bad = 1'b1; end
                if (acc_we !== 1'b0) begin fail_line(6, "idle acc_we", acc_we, 0); bad = 1'b1; end
                if (illegal !== 1'b0) begin fail_line(10, "idle illegal", illegal, 0); bad = 1'b1; end
                // R9
                if (pc_out !== exp_pc) begin fail_line(9, "pc_out", pc_out, exp_pc); bad = 1'b1; end
                // R5 (flags)
                if (flag_z !== exp_z) begin fail_line(5, "flag_z", flag_z, exp_z); bad = 1'b1; end
                if (flag_n !== exp_n) begin fail_line(5, "flag_n", flag_n, exp_n); bad = 1'b1; end
            end
            if (bad) n_fail++;
        end
    end

    function automatic cyc_t mk(input bit ca, input logic [15:0] a, input bit we,
                                input logic [7:0] wd, input bit dn, input bit awe,
                                input logic [7:0] ad, input bit ill, input int req);
        cyc_t c;
        c.chk_addr = ca; c.addr = a; c.we = we; c.wd = wd; c.dn = dn;
        c.awe = awe; c.ad = ad; c.ill = ill; c.req = req;
        return c;
    endfunction

    // cls: 0 read, 1 write, 2 read-modify-write, -1 unsupported
    task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] x,
                       input logic [7:0] a, input bit poke);
        int cls;
        bit idx;
        logic [7:0] base, ea, old, nv;
        int areq;
        case (op)
            8'hE6: begin cls = 2; idx = 1'b0; end
            8'hF6: begin cls = 2; idx = 1'b1; end
            8'hA5: begin cls = 0; idx = 1'b0; end
            8'hB5: begin cls = 0; idx = 1'b1; end
            8'h85: begin cls = 1; idx = 1'b0; end
            8'h95: begin cls = 1; idx = 1'b1; end
            default: begin cls = -1; idx = 1'b0; end
        endcase
        base = mem[pc];
        ea   = idx ? 8'(base + x) : base;
        old  = mem[{8'h00, ea}];
        nv   = 8'(old + 8'd1);
        areq = idx ? 3 : 2; // R3 / R2 address checks
        @(negedge clk); #1;
        opcode = op; pc_in = pc; x_in = x; acc_in = a; start = 1'b1;
        if (cls < 0) begin
            q.push_back(mk(0, 16'h0, 0, 8'h0, 0, 0, 8'h0, 1, 10));
        end else begin
            if (idx) q.push_back(mk(0, 16'h0, 0, 8'h0, 0, 0, 8'h0, 0, 3));
            q.push_back(mk(1, pc, 0, 8'h0, 0, 0, 8'h0, 0, areq));
            if (cls == 1) begin
                // R7: store in the cycle after the operand byte
                q.push_back(mk(1, {8'h00, ea}, 1, a, 1, 0, 8'h0, 0, 7));
            end else if (cls == 0) begin
                // R6: load read then write-back
                q.push_back(mk(1, {8'h00, ea}, 0, 8'h0, 0, 0, 8'h0, 0, areq));
                q.push_back(mk(0, 16'h0, 0, 8'h0, 1, 1, old, 0, 6));
                exp_z = (old == 8'h00); exp_n = old[7];
            end else begin
                // R4: read, write old, write old+1
                q.push_back(mk(1, {8'h00, ea}, 0, 8'h0, 0, 0, 8'h0, 0, areq));
                q.push_back(mk(1, {8'h00, ea}, 1, old, 0, 0, 8'h0, 0, 4));
                q.push_back(mk(1, {8'h00, ea}, 1, nv, 1, 0, 8'h0, 0, 4));
                exp_z = (nv == 8'h00); exp_n = nv[7];
            end
            exp_pc = 16'(pc + 16'd1);
        end
        @(negedge clk); #1;
        if (poke) begin
            // R11: start held with another opcode and address while busy
            opcode = 8'h00; pc_in = 16'hBEEF;
            @(negedge clk); #1;
        end
        start = 1'b0;
        wait (q.size() == 0);
        @(negedge clk); #1;
        if (cls == 1) begin
            n_chk++;
            if (mem[{8'h00, ea}] !== a) begin
                fail_line(7, "stored byte", mem[{8'h00, ea}], a); n_fail++;
            end
        end else if (cls == 2) begin
            n_chk++;
            if (mem[{8'h00, ea}] !== nv) begin
                fail_line(4, "incremented byte", mem[{8'h00, ea}], nv); n_fail++;
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        n_chk++;
        if (mem_we !== 1'b0 || done !== 1'b0 || acc_we !== 1'b0 || illegal !== 1'b0 ||
            pc_out !== 16'h0 || flag_z !== 1'b0 || flag_n !== 1'b0) begin
            fail_line(1, "reset state", {mem_we, done, acc_we, illegal, flag_z, flag_n}, 0);
            n_fail++;
        end
        running = 1'b1;

        // R2 increment direct
        mem[16'h0200] = 8'h10; mem[16'h0010] = 8'h05;
        run(8'hE6, 16'h0200, 8'h33, 8'h00, 0);
        // R3 increment indexed, 0x44 + 0xED wraps to 0x31
        mem[16'h4322] = 8'h44; mem[16'h0031] = 8'h05;
        run(8'hF6, 16'h4322, 8'hED, 8'h00, 0);
        // R5 zero result
        mem[16'h0300] = 8'h20; mem[16'h0020] = 8'hFF;
        run(8'hE6, 16'h0300, 8'h00, 8'h00, 0);
        // R5 negative result
        mem[16'h0400] = 8'h80; mem[16'h0085] = 8'h7F;
        run(8'hF6, 16'h0400, 8'h05, 8'h00, 0);
        // R6 load direct, zero byte
        mem[16'h0500] = 8'h40; mem[16'h0040] = 8'h00;
        run(8'hA5, 16'h0500, 8'h00, 8'h00, 0);
        // R6 load indexed with wrap, negative byte
        mem[16'h0600] = 8'hF0; mem[16'h0010] = 8'hC3;
        run(8'hB5, 16'h0600, 8'h20, 8'h00, 0);
        // R7 store direct, flags stay
        mem[16'h0700] = 8'h55;
        run(8'h85, 16'h0700, 8'h00, 8'h5A, 0);
        // R7 store indexed with wrap
        mem[16'hFFFE] = 8'hFF;
        run(8'h95, 16'hFFFE, 8'h02, 8'hA7, 0);
        // R10 unsupported opcodes
        run(8'h00, 16'h1234, 8'h00, 8'h00, 0);
        run(8'hFF, 16'h2345, 8'h11, 8'h99, 0);
        // R11 start while busy
        mem[16'h0800] = 8'h60; mem[16'h0061] = 8'h41;
        run(8'hF6, 16'h0800, 8'h01, 8'h00, 1);
        // R6 load of positive nonzero byte clears both flags
        mem[16'h0900] = 8'h70; mem[16'h0070] = 8'h12;
        run(8'hA5, 16'h0900, 8'h00, 8'h00, 0);
        // R8 back-to-back: store direct right after
        mem[16'h0A00] = 8'h90;
        run(8'h85, 16'h0A00, 8'h00, 8'h00, 0);

        repeat (3) @(negedge clk);
        running = 1'b0;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule